// File: doc/BRIEF.md
# Flash Region Access Permission Checker

This block sits in front of a serial-flash controller and decides, one request at a time, whether an access may go ahead. A request names one of three masters (host processor, management engine, Ethernet controller), a 16-bit requestor ID, a flash byte address, a read or write direction and the serial command opcode. The block finds the flash region that holds the address, then combines the master's permission word, the rights every master has to its own region, a requestor-ID match, a short list of forbidden opcodes and two write-protect inputs. The verdict comes out one clock later.

Region bounds, permission words, the forbidden opcode list and the generation mode are static inputs, driven by whatever logic loads the flash descriptor. Each denial is also latched into a sticky error record, holding the master and the reason, until a write-one-to-clear pulse.

Top module: `flash_guard`

## Requirements
- R1: The address is split into a 4 KiB block number (address bits 24:12). Region r (0 descriptor, 1 host firmware, 2 management engine, 3 Ethernet, 4 platform data) holds the block when base_r <= block <= limit_r. A region with base above limit is unused. When regions overlap, the lowest index wins. An address in no region is denied.
- R2: In a master's 32-bit permission word, bit 16+r grants read of region r and bit 24+r grants write of region r.
- R3: Whatever its permission word says, the host (master 0) may read and write region 1, the management engine (master 1) region 2, and Ethernet (master 2) region 3.
- R4: Masters 0 and 1 must present requestor ID 0x0000. Master 2 must present 0x0218 when `eth_rid_alt` is 0 and 0x0118 when it is 1. Any mismatch, and master index 3, is denied.
- R5: A request whose opcode equals any non-zero entry of the four-entry forbidden list is denied. A 0x00 entry matches nothing.
- R6: When either `bios_wp` or `global_wp` is high, every write is denied. Reads are unaffected.
- R7: A request sampled at a clock edge gets its verdict on `resp_valid`/`resp_allow` after that same edge. `resp_allow` is low whenever `resp_valid` is low.
- R8: A denial sets `err_flag` and records the master and the cause (1 requestor ID, 2 opcode, 3 region or permission, 4 write-protect). When several causes apply, the lower code wins. The record keeps the first denial until `err_clr` is high at an edge. A denial at that same edge is recorded after the clear.
- R9: After reset, `resp_valid`, `resp_allow` and `err_flag` are low and the error cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_master | input | 2 | Master index (0 host, 1 management, 2 Ethernet) |
| req_rid | input | 16 | Requestor ID |
| req_addr | input | 25 | Flash byte address |
| req_write | input | 1 | 1 write, 0 read |
| req_opcode | input | 8 | Serial command opcode |
| region_base | input | 5x13 | Base block per region |
| region_limit | input | 5x13 | Limit block per region |
| master_perm | input | 3x32 | Permission word per master |
| forbid_ops | input | 4x8 | Forbidden opcode list |
| eth_rid_alt | input | 1 | Selects the alternative Ethernet requestor ID |
| bios_wp | input | 1 | Firmware-range write protect |
| global_wp | input | 1 | Global write protect |
| err_clr | input | 1 | Write-one-to-clear for the error record |
| resp_valid | output | 1 | Verdict present |
| resp_allow | output | 1 | 1 allowed, 0 denied |
| err_flag | output | 1 | Sticky denial flag |
| err_master | output | 2 | Master of the recorded denial |
| err_cause | output | 3 | Cause of the recorded denial |

## Verification
The hardest state to reach is an overlap between two valid regions, where only the priority order decides which permission bit applies. The bench gives the platform-data region the same bounds as the Ethernet region. It then sends a management-engine write that the Ethernet bit allows and the platform-data bit would refuse. A clear pulse and a new denial in the same cycle is the other narrow case. The bench drives both in one cycle and checks that the new cause survives.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int NUM_MASTERS = 3;
    localparam int NUM_REGIONS = 5;
    localparam int NUM_FORBID  = 4;
    localparam int RID_W       = 16;
    localparam int OP_W        = 8;
    localparam int PERM_W      = 32;
    localparam int RD_LSB      = 16;
    localparam int WR_LSB      = 24;

    typedef enum logic [2:0] {
        REG_DESC  = 3'd0,
        REG_FW    = 3'd1,
        REG_MGMT  = 3'd2,
        REG_ETH   = 3'd3,
        REG_PDATA = 3'd4
    } region_e;

    typedef enum logic [1:0] {
        MST_HOST = 2'd0,
        MST_MGMT = 2'd1,
        MST_ETH  = 2'd2,
        MST_NONE = 2'd3
    } master_e;

    typedef enum logic [2:0] {
        DENY_NONE   = 3'd0,
        DENY_RID    = 3'd1,
        DENY_OPCODE = 3'd2,
        DENY_REGION = 3'd3,
        DENY_WP     = 3'd4
    } deny_e;

    typedef struct packed {
        logic    valid;
        logic    allow;
    } verdict_t;

    typedef struct packed {
        logic       flag;
        logic [1:0] master;
        deny_e      cause;
    } err_rec_t;

    function automatic region_e home_region(input logic [1:0] m);
        case (m)
            MST_HOST: return REG_FW;
            MST_MGMT: return REG_MGMT;
            default:  return REG_ETH;
        endcase
    endfunction

    function automatic logic [RID_W-1:0] expected_rid(input logic [1:0] m, input logic alt);
        if (m == MST_ETH) return alt ? 16'h0118 : 16'h0218;
        return '0;
    endfunction

endpackage

// File: rtl/flash_region_map.sv
module flash_region_map
    import flash_guard_pkg::*;
#(
    parameter int N_REG = NUM_REGIONS,
    parameter int BLK_W = 13,
    localparam int IDX_W = $clog2(N_REG)
) (
    input  logic [BLK_W-1:0]            blk,
    input  logic [N_REG-1:0][BLK_W-1:0] base,
    input  logic [N_REG-1:0][BLK_W-1:0] limit,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx
);
    logic [N_REG-1:0] in_rng;

    for (genvar r = 0; r < N_REG; r++) begin : g_rng
        assign in_rng[r] = (base[r] <= limit[r]) && (blk >= base[r]) && (blk <= limit[r]);
    end

    // Scan from the top so the lowest matching index is the one kept.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int r = N_REG - 1; r >= 0; r--) begin
            if (in_rng[r]) begin
                hit = 1'b1;
                idx = IDX_W'(r);
            end
        end
    end
endmodule

// File: rtl/flash_rights.sv
module flash_rights
    import flash_guard_pkg::*;
#(
    parameter int N_REG = NUM_REGIONS,
    parameter int N_MST = NUM_MASTERS,
    localparam int IDX_W = $clog2(N_REG)
) (
    input  logic [1:0]                    master,
    input  logic [N_MST-1:0][PERM_W-1:0]  perm,
    input  logic                          hit,
    input  logic [IDX_W-1:0]              idx,
    input  logic                          write,
    output logic                          granted
);
    logic [PERM_W-1:0] word;
    logic              bit_ok;
    logic              own_ok;

    always_comb begin
        word = '0;
        for (int m = 0; m < N_MST; m++) begin
            if (master == 2'(m)) word = perm[m];
        end
        bit_ok = 1'b0;
        for (int r = 0; r < N_REG; r++) begin
            if (idx == IDX_W'(r)) bit_ok = write ? word[WR_LSB + r] : word[RD_LSB + r];
        end
    end

    assign own_ok  = (master != MST_NONE) && (idx == IDX_W'(home_region(master)));
    assign granted = hit && (bit_ok || own_ok);
endmodule

// File: rtl/flash_op_filter.sv
module flash_op_filter
    import flash_guard_pkg::*;
#(
    parameter int N_FORBID = NUM_FORBID
) (
    input  logic [1:0]                     master,
    input  logic [RID_W-1:0]               rid,
    input  logic                           rid_alt,
    input  logic [OP_W-1:0]                opcode,
    input  logic [N_FORBID-1:0][OP_W-1:0]  forbid,
    output logic                           rid_ok,
    output logic                           op_ok
);
    logic [N_FORBID-1:0] match;

    for (genvar k = 0; k < N_FORBID; k++) begin : g_op
        assign match[k] = (forbid[k] != '0) && (forbid[k] == opcode);
    end

    assign rid_ok = (master != MST_NONE) && (rid == expected_rid(master, rid_alt));
    assign op_ok  = ~|match;
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W    = 25,
    parameter int BLK_SHIFT = 12,
    parameter int N_REG     = NUM_REGIONS,
    parameter int N_MST     = NUM_MASTERS,
    parameter int N_FORBID  = NUM_FORBID,
    localparam int BLK_W    = ADDR_W - BLK_SHIFT,
    localparam int IDX_W    = $clog2(N_REG)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            req_valid,
    input  logic [1:0]                      req_master,
    input  logic [RID_W-1:0]                req_rid,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic                            req_write,
    input  logic [OP_W-1:0]                 req_opcode,
    input  logic [N_REG-1:0][BLK_W-1:0]     region_base,
    input  logic [N_REG-1:0][BLK_W-1:0]     region_limit,
    input  logic [N_MST-1:0][PERM_W-1:0]    master_perm,
    input  logic [N_FORBID-1:0][OP_W-1:0]   forbid_ops,
    input  logic                            eth_rid_alt,
    input  logic                            bios_wp,
    input  logic                            global_wp,
    input  logic                            err_clr,
    output logic                            resp_valid,
    output logic                            resp_allow,
    output logic                            err_flag,
    output logic [1:0]                      err_master,
    output logic [2:0]                      err_cause
);
    logic             hit, granted, rid_ok, op_ok, wp_block;
    logic [IDX_W-1:0] idx;
    deny_e            cause;
    verdict_t         vq;
    err_rec_t         eq;

    flash_region_map #(.N_REG(N_REG), .BLK_W(BLK_W)) u_map (
        .blk   (req_addr[ADDR_W-1:BLK_SHIFT]),
        .base  (region_base),
        .limit (region_limit),
        .hit   (hit),
        .idx   (idx)
    );

    flash_rights #(.N_REG(N_REG), .N_MST(N_MST)) u_rights (
        .master  (req_master),
        .perm    (master_perm),
        .hit     (hit),
        .idx     (idx),
        .write   (req_write),
        .granted (granted)
    );

    flash_op_filter #(.N_FORBID(N_FORBID)) u_filt (
        .master  (req_master),
        .rid     (req_rid),
        .rid_alt (eth_rid_alt),
        .opcode  (req_opcode),
        .forbid  (forbid_ops),
        .rid_ok  (rid_ok),
        .op_ok   (op_ok)
    );

    assign wp_block = req_write && (bios_wp || global_wp);

    always_comb begin
        if (!rid_ok)       cause = DENY_RID;
        else if (!op_ok)   cause = DENY_OPCODE;
        else if (!granted) cause = DENY_REGION;
        else if (wp_block) cause = DENY_WP;
        else               cause = DENY_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vq <= '0;
            eq <= '{flag: 1'b0, master: 2'd0, cause: DENY_NONE};
        end else begin
            vq.valid <= req_valid;
            vq.allow <= req_valid && (cause == DENY_NONE);
            if (req_valid && (cause != DENY_NONE) && (!eq.flag || err_clr)) begin
                eq.flag   <= 1'b1;
                eq.master <= req_master;
                eq.cause  <= cause;
            end else if (err_clr) begin
                eq <= '{flag: 1'b0, master: 2'd0, cause: DENY_NONE};
            end
        end
    end

    assign resp_valid = vq.valid;
    assign resp_allow = vq.allow;
    assign err_flag   = eq.flag;
    assign err_master = eq.master;
    assign err_cause  = eq.cause;
endmodule

// File: rtl/flash_guard_checker.sv
module flash_guard_checker
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W   = 25,
    parameter int N_FORBID = NUM_FORBID
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           req_valid,
    input logic [1:0]                     req_master,
    input logic [RID_W-1:0]               req_rid,
    input logic                           req_write,
    input logic [OP_W-1:0]                req_opcode,
    input logic [N_FORBID-1:0][OP_W-1:0]  forbid_ops,
    input logic                           bios_wp,
    input logic                           global_wp,
    input logic                           err_clr,
    input logic                           resp_valid,
    input logic                           resp_allow,
    input logic                           err_flag
);
    assert_verdict_follows_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);
    assert_idle_follows_R7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);
    assert_no_allow_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> !resp_allow);
    assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && (bios_wp || global_wp)) |=> !resp_allow);
    assert_host_rid_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_master == 2'd0 && req_rid != 16'h0000) |=> !resp_allow);

    for (genvar k = 0; k < N_FORBID; k++) begin : g_forbid
        assert_forbidden_op_R5: assert property (@(posedge clk) disable iff (rst)
            (req_valid && forbid_ops[k] != '0 && req_opcode == forbid_ops[k]) |=> !resp_allow);
    end

    assert_deny_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_allow) |-> err_flag);
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> err_flag);
endmodule

bind flash_guard flash_guard_checker #(.ADDR_W(ADDR_W), .N_FORBID(N_FORBID)) u_chk (.*);

// File: tb/flash_guard_bench.sv
module flash_guard_bench;
    import flash_guard_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_master = '0;
    logic [15:0] req_rid = '0;
    logic [24:0] req_addr = '0;
    logic req_write = 1'b0;
    logic [7:0] req_opcode = '0;
    logic [4:0][12:0] region_base;
    logic [4:0][12:0] region_limit;
    logic [2:0][31:0] master_perm;
    logic [3:0][7:0] forbid_ops = '0;
    logic eth_rid_alt = 1'b0, bios_wp = 1'b0, global_wp = 1'b0, err_clr = 1'b0;
    logic resp_valid, resp_allow, err_flag;
    logic [1:0] err_master;
    logic [2:0] err_cause;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    flash_guard u_flash_guard (.*);

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] m, input logic [15:0] rid, input logic [12:0] blk,
                        input logic wr, input logic [7:0] op);
        req_valid = 1'b1; req_master = m; req_rid = rid;
        req_addr = {blk, 12'h0A4}; req_write = wr; req_opcode = op;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 resp_valid", resp_valid, 0);
        check("R9 resp_allow", resp_allow, 0);
        check("R9 err_flag", err_flag, 0);
        check("R9 err_cause", err_cause, 0);
    endtask

    task automatic t_perm_bits();
        send(0, 16'h0, 13'h000, 0, 8'h03); check("R2 host read descriptor", resp_allow, 1);
        send(0, 16'h0, 13'h000, 1, 8'h02); check("R2 host write descriptor", resp_allow, 0);
        send(0, 16'h0, 13'h400, 1, 8'h02); check("R2 host write ethernet", resp_allow, 1);
        send(1, 16'h0, 13'h300, 0, 8'h03); check("R2 mgmt read firmware", resp_allow, 0);
        send(1, 16'h0, 13'h400, 0, 8'h03); check("R2 mgmt read ethernet", resp_allow, 1);
    endtask

    task automatic t_own_region();
        master_perm[0] = 32'h0;
        send(0, 16'h0, 13'h300, 1, 8'h02); check("R3 host own write", resp_allow, 1);
        send(0, 16'h0, 13'h300, 0, 8'h03); check("R3 host own read", resp_allow, 1);
        send(2, 16'h0218, 13'h405, 1, 8'h02); check("R3 eth own write", resp_allow, 1);
        send(2, 16'h0218, 13'h300, 0, 8'h03); check("R3 eth other read", resp_allow, 0);
        master_perm[0] = 32'h1A1B0000;
    endtask

    task automatic t_rid();
        send(0, 16'h0001, 13'h300, 0, 8'h03); check("R4 host bad rid", resp_allow, 0);
        send(2, 16'h0118, 13'h400, 0, 8'h03); check("R4 eth alt rid in mode 0", resp_allow, 0);
        eth_rid_alt = 1'b1;
        send(2, 16'h0118, 13'h400, 0, 8'h03); check("R4 eth alt rid in mode 1", resp_allow, 1);
        send(2, 16'h0218, 13'h400, 0, 8'h03); check("R4 eth base rid in mode 1", resp_allow, 0);
        eth_rid_alt = 1'b0;
        send(3, 16'h0000, 13'h300, 0, 8'h03); check("R4 master index 3", resp_allow, 0);
    endtask

    task automatic t_opcode();
        forbid_ops[2] = 8'hC7;
        send(0, 16'h0, 13'h300, 1, 8'hC7); check("R5 forbidden opcode", resp_allow, 0);
        send(0, 16'h0, 13'h300, 1, 8'h02); check("R5 permitted opcode", resp_allow, 1);
        forbid_ops = '0;
        send(0, 16'h0, 13'h300, 0, 8'h00); check("R5 empty entries match nothing", resp_allow, 1);
    endtask

    task automatic t_region();
        send(0, 16'h0, 13'h800, 0, 8'h03); check("R1 unmapped address", resp_allow, 0);
        send(0, 16'h0, 13'h1FFF, 1, 8'h02); check("R1 unused region base above limit", resp_allow, 0);
        send(0, 16'h0, 13'h3FF, 0, 8'h03); check("R1 limit block inclusive", resp_allow, 1);
        region_base[4] = 13'h400; region_limit[4] = 13'h40F;
        send(1, 16'h0, 13'h408, 1, 8'h02); check("R1 overlap lowest index wins", resp_allow, 1);
        region_base[4] = 13'h1FFF; region_limit[4] = 13'h0;
    endtask

    task automatic t_wp();
        bios_wp = 1'b1;
        send(0, 16'h0, 13'h300, 1, 8'h02); check("R6 firmware wp write", resp_allow, 0);
        send(0, 16'h0, 13'h300, 0, 8'h03); check("R6 firmware wp read", resp_allow, 1);
        bios_wp = 1'b0; global_wp = 1'b1;
        send(1, 16'h0, 13'h100, 1, 8'h02); check("R6 global wp write", resp_allow, 0);
        global_wp = 1'b0;
        send(1, 16'h0, 13'h100, 1, 8'h02); check("R6 wp released", resp_allow, 1);
    endtask

    task automatic t_latency();
        send(0, 16'h0, 13'h300, 0, 8'h03);
        check("R7 valid after request", resp_valid, 1);
        @(negedge clk);
        check("R7 valid drops", resp_valid, 0);
        check("R7 allow low when idle", resp_allow, 0);
    endtask

    task automatic t_err();
        clear_err();
        check("R8 cleared", err_flag, 0);
        send(0, 16'h0005, 13'h300, 0, 8'h03);
        check("R8 flag set", err_flag, 1);
        check("R8 cause rid", err_cause, 1);
        check("R8 master", err_master, 0);
        send(1, 16'h0, 13'h300, 0, 8'h03);
        check("R8 first kept", err_cause, 1);
        err_clr = 1'b1;
        send(2, 16'h0218, 13'h405, 1, 8'h02);
        forbid_ops[0] = 8'h00;
        err_clr = 1'b0;
        check("R8 wp no deny when off", err_flag, 0);
        global_wp = 1'b1;
        send(2, 16'h0218, 13'h405, 1, 8'h02);
        global_wp = 1'b0;
        check("R8 cause wp", err_cause, 4);
        check("R8 eth master", err_master, 2);
        forbid_ops[1] = 8'hD8;
        err_clr = 1'b1;
        send(1, 16'h0, 13'h100, 0, 8'hD8);
        err_clr = 1'b0;
        check("R8 set wins over clear", err_flag, 1);
        check("R8 cause opcode", err_cause, 2);
        clear_err();
        send(0, 16'h0007, 13'h300, 0, 8'hD8);
        check("R8 rid outranks opcode", err_cause, 1);
        forbid_ops = '0;
        clear_err();
        send(1, 16'h0, 13'h300, 0, 8'h03);
        check("R8 cause region", err_cause, 3);
        clear_err();
        check("R8 flag cleared", err_flag, 0);
    endtask

    initial begin
        region_base[0] = 13'h000; region_limit[0] = 13'h000;
        region_base[1] = 13'h200; region_limit[1] = 13'h3FF;
        region_base[2] = 13'h001; region_limit[2] = 13'h1FF;
        region_base[3] = 13'h400; region_limit[3] = 13'h40F;
        region_base[4] = 13'h1FFF; region_limit[4] = 13'h000;
        master_perm[0] = 32'h1A1B0000;
        master_perm[1] = 32'h0C0D0000;
        master_perm[2] = 32'h00000000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_perm_bits();
        t_own_region();
        t_rid();
        t_opcode();
        t_region();
        t_wp();
        t_latency();
        t_err();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule